// File: doc/BRIEF.md
# Transmit-Diversity Receive Decoder with Hard Symbol Detection

This block sits on the receive side of a downlink chain, ahead of descrambling. It accepts complex samples (16-bit real and 16-bit imaginary parts) from up to two antenna ports. A two-bit antenna code selects how each sample is treated. In single-port mode each sample is taken as a layer symbol as it stands. In two-port mode the block collects the samples in time pairs and undoes the two-antenna space-frequency block code. This recovers two layer symbols from each pair. Each recovered symbol is sliced against fixed-point constellation thresholds into 2, 4 or 6 hard bits.

When two layers are present, the symbols are put back into a single codeword order: the layer-0 symbol comes first and the layer-1 symbol second. The output is a stream of bit groups, one group per symbol, each marked by a valid pulse. The pipeline has a fixed latency and accepts a new sample on every cycle. The one exception is the cycle directly after a pair completes, which must not carry a single-port sample.

Constellation levels are odd multiples of a level unit `LVL_UNIT`, which defaults to 4096. The slicing thresholds sit at 0, ±2·LVL_UNIT, ±4·LVL_UNIT and ±6·LVL_UNIT.

Top module: `sfbc_rx_detect`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `out_valid` is 0 and `out_bits` is 0.
- R2: Antenna code 01 (single port): the symbol is the port-0 sample unscaled, and port 1 is ignored. Its bits appear with `out_valid` 3 cycles after the clock edge that accepts the sample.
- R3: Antenna code 10 (two ports): two consecutive accepted samples form the pair (2i, 2i+1). The block forms x0 = (y0(2i) + conj(y1(2i+1)))/√2 and x1 = (y0(2i+1) − conj(y1(2i)))/√2, with 1/√2 taken as 181/256.
- R4: Modulation code 00 (QPSK), and likewise the unused code 11: `out_bits[1]` is 1 when I < 0, `out_bits[0]` is 1 when Q < 0, and `out_bits[5:2]` are 0.
- R5: Modulation code 01 (16QAM): bit 3 is the I sign and bit 2 is the Q sign, each 1 when negative. Bit 1 is 1 when |I| ≥ 2·LVL_UNIT, bit 0 is 1 when |Q| ≥ 2·LVL_UNIT, and bits 5:4 are 0.
- R6: Modulation code 10 (64QAM): bit 5 is the I sign and bit 4 the Q sign. Bit 3 is |I| ≥ 4·LVL_UNIT and bit 2 is |Q| ≥ 4·LVL_UNIT. Bit 1 is (|I| < 2·LVL_UNIT or |I| ≥ 6·LVL_UNIT), and bit 0 is the same test on Q.
- R7: A sample with antenna code 00 or 11 produces no output. It also discards any half-collected pair.
- R8: For a pair, the modulation code carried with the second sample applies to both symbols. The code on the first sample is ignored.
- R9: Delayer order: x0 bits appear 3 cycles after the edge that accepts the second sample of the pair, and x1 bits appear one cycle later. `out_valid` pulses exactly once per symbol. Pairs may arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present on this cycle |
| ant_code | input | 2 | 01 single port, 10 two ports, other values drop the sample |
| mod_code | input | 2 | 00 QPSK, 01 16QAM, 10 64QAM, 11 treated as QPSK |
| y0_re | input | 16 | Port 0 sample, real part, signed |
| y0_im | input | 16 | Port 0 sample, imaginary part, signed |
| y1_re | input | 16 | Port 1 sample, real part, signed |
| y1_im | input | 16 | Port 1 sample, imaginary part, signed |
| out_valid | output | 1 | One pulse per detected symbol |
| out_bits | output | 6 | Hard bits, LSB-aligned, unused upper bits zero |

## Verification
A single-port symbol's bits are due 3 cycles after the edge that accepts it. For a pair, the first symbol is due 3 cycles after the edge that takes the second sample, and the second symbol one cycle after that. The bench drives inputs on the falling edge and notes the cycle counter there. For each symbol it queues the expected bits together with the exact cycle they are due. A falling-edge monitor then compares every valid output with the head of that queue, checking both the bits and the cycle. An output with nothing queued, and a queued entry whose cycle has passed without an output, are both reported as failures.

// File: rtl/sfbc_rx_pkg.sv
package sfbc_rx_pkg;
    localparam int SAMP_W    = 16;
    localparam int COMB_W    = SAMP_W + 2;
    localparam int BITS_W    = 6;
    localparam int NUM_LANES = 2;

    typedef struct packed {
        logic signed [SAMP_W-1:0] re;
        logic signed [SAMP_W-1:0] im;
    } samp_t;

    typedef struct packed {
        logic signed [COMB_W-1:0] re;
        logic signed [COMB_W-1:0] im;
    } comb_t;

    typedef enum logic [1:0] {
        ANT_NONE = 2'd0,
        ANT_ONE  = 2'd1,
        ANT_TWO  = 2'd2
    } ant_mode_e;

    typedef enum logic [1:0] {
        QAM4  = 2'd0,
        QAM16 = 2'd1,
        QAM64 = 2'd2
    } qam_e;

    function automatic ant_mode_e ant_decode(input logic [1:0] code);
        case (code)
            2'b01:   return ANT_ONE;
            2'b10:   return ANT_TWO;
            default: return ANT_NONE;
        endcase
    endfunction

    function automatic qam_e qam_decode(input logic [1:0] code);
        case (code)
            2'b01:   return QAM16;
            2'b10:   return QAM64;
            default: return QAM4;
        endcase
    endfunction

    function automatic comb_t widen(input samp_t s);
        comb_t c;
        c.re = COMB_W'(s.re);
        c.im = COMB_W'(s.im);
        return c;
    endfunction
endpackage

// File: rtl/sfbc_pair_buffer.sv
module sfbc_pair_buffer
    import sfbc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [1:0] ant_code,
    input  logic [1:0] mod_code,
    input  samp_t      y0,
    input  samp_t      y1,
    output logic       pair_valid,
    output logic       pair_dual,
    output qam_e       pair_mod,
    output samp_t      a0,
    output samp_t      b0,
    output samp_t      a1,
    output samp_t      b1,
    output logic       phase
);
    samp_t hold0, hold1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_valid <= 1'b0;
            pair_dual  <= 1'b0;
            pair_mod   <= QAM4;
            a0 <= '0;
            b0 <= '0;
            a1 <= '0;
            b1 <= '0;
            hold0 <= '0;
            hold1 <= '0;
            phase <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (in_valid) begin
                case (ant_decode(ant_code))
                    ANT_ONE: begin
                        pair_valid <= 1'b1;
                        pair_dual  <= 1'b0;
                        pair_mod   <= qam_decode(mod_code);
                        a0         <= y0;
                        phase      <= 1'b0;
                    end
                    ANT_TWO: begin
                        if (!phase) begin
                            hold0 <= y0;
                            hold1 <= y1;
                            phase <= 1'b1;
                        end else begin
                            pair_valid <= 1'b1;
                            pair_dual  <= 1'b1;
                            pair_mod   <= qam_decode(mod_code);
                            a0         <= hold0;
                            a1         <= hold1;
                            b0         <= y0;
                            b1         <= y1;
                            phase      <= 1'b0;
                        end
                    end
                    default: phase <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/sfbc_combiner.sv
module sfbc_combiner
    import sfbc_rx_pkg::*;
#(
    parameter int RECIP_Q  = 181,
    parameter int RECIP_SH = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pair_valid,
    input  logic  pair_dual,
    input  qam_e  pair_mod,
    input  samp_t a0,
    input  samp_t b0,
    input  samp_t a1,
    input  samp_t b1,
    output logic  comb_valid,
    output qam_e  comb_mod,
    output logic  comb_dual,
    output comb_t x0,
    output comb_t x1
);
    localparam int SUM_W  = SAMP_W + 1;
    localparam int RQ_W   = $clog2(RECIP_Q + 1) + 1;
    localparam int PROD_W = SUM_W + RQ_W;
    localparam logic signed [RQ_W-1:0] RQ = RQ_W'(RECIP_Q);

    function automatic logic signed [COMB_W-1:0] scale(input logic signed [SUM_W-1:0] s);
        logic signed [PROD_W-1:0] p;
        p = PROD_W'(s) * PROD_W'(RQ);
        return COMB_W'(p >>> RECIP_SH);
    endfunction

    logic signed [SUM_W-1:0] s0_re, s0_im, s1_re, s1_im;
    comb_t x0_d, x1_d;

    always_comb begin
        s0_re = SUM_W'(a0.re) + SUM_W'(b1.re);
        s0_im = SUM_W'(a0.im) - SUM_W'(b1.im);
        s1_re = SUM_W'(b0.re) - SUM_W'(a1.re);
        s1_im = SUM_W'(b0.im) + SUM_W'(a1.im);
        if (pair_dual) begin
            x0_d.re = scale(s0_re);
            x0_d.im = scale(s0_im);
            x1_d.re = scale(s1_re);
            x1_d.im = scale(s1_im);
        end else begin
            x0_d = widen(a0);
            x1_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            comb_valid <= 1'b0;
            comb_mod   <= QAM4;
            comb_dual  <= 1'b0;
            x0 <= '0;
            x1 <= '0;
        end else begin
            comb_valid <= pair_valid;
            comb_mod   <= pair_mod;
            comb_dual  <= pair_dual;
            x0 <= x0_d;
            x1 <= x1_d;
        end
    end
endmodule

// File: rtl/sfbc_slicer.sv
module sfbc_slicer
    import sfbc_rx_pkg::*;
#(
    parameter int LVL_UNIT = 4096
) (
    input  comb_t              x,
    input  qam_e               mod,
    output logic [BITS_W-1:0]  bits
);
    localparam logic signed [COMB_W-1:0] T2 = COMB_W'(2 * LVL_UNIT);
    localparam logic signed [COMB_W-1:0] T4 = COMB_W'(4 * LVL_UNIT);
    localparam logic signed [COMB_W-1:0] T6 = COMB_W'(6 * LVL_UNIT);
    localparam logic signed [COMB_W-1:0] N2 = COMB_W'(-2 * LVL_UNIT);
    localparam logic signed [COMB_W-1:0] N4 = COMB_W'(-4 * LVL_UNIT);
    localparam logic signed [COMB_W-1:0] N6 = COMB_W'(-6 * LVL_UNIT);

    function automatic logic at_least(input logic signed [COMB_W-1:0] v,
                                      input logic signed [COMB_W-1:0] t,
                                      input logic signed [COMB_W-1:0] nt);
        return (v >= t) || (v <= nt);
    endfunction

    logic si, sq, i2, q2, i4, q4, i6, q6;

    always_comb begin
        si = x.re[COMB_W-1];
        sq = x.im[COMB_W-1];
        i2 = at_least(x.re, T2, N2);
        q2 = at_least(x.im, T2, N2);
        i4 = at_least(x.re, T4, N4);
        q4 = at_least(x.im, T4, N4);
        i6 = at_least(x.re, T6, N6);
        q6 = at_least(x.im, T6, N6);
        case (mod)
            QAM16:   bits = {2'b00, si, sq, i2, q2};
            QAM64:   bits = {si, sq, i4, q4, (!i2 || i6), (!q2 || q6)};
            default: bits = {4'b0000, si, sq};
        endcase
    end
endmodule

// File: rtl/sfbc_delayer.sv
module sfbc_delayer
    import sfbc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slc_valid,
    input  logic              slc_dual,
    input  qam_e              slc_mod,
    input  logic [BITS_W-1:0] bits_a,
    input  logic [BITS_W-1:0] bits_b,
    output logic              out_valid,
    output logic [BITS_W-1:0] out_bits,
    output qam_e              out_mod,
    output logic              pend_valid
);
    logic [BITS_W-1:0] pend_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_bits   <= '0;
            out_mod    <= QAM4;
            pend_valid <= 1'b0;
            pend_bits  <= '0;
        end else if (slc_valid) begin
            out_valid  <= 1'b1;
            out_bits   <= bits_a;
            out_mod    <= slc_mod;
            pend_valid <= slc_dual;
            pend_bits  <= bits_b;
        end else if (pend_valid) begin
            out_valid  <= 1'b1;
            out_bits   <= pend_bits;
            pend_valid <= 1'b0;
        end else begin
            out_valid  <= 1'b0;
        end
    end
endmodule

// File: rtl/sfbc_rx_detect.sv
module sfbc_rx_detect
    import sfbc_rx_pkg::*;
#(
    parameter int LVL_UNIT = 4096,
    parameter int RECIP_Q  = 181,
    parameter int RECIP_SH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [1:0]               ant_code,
    input  logic [1:0]               mod_code,
    input  logic signed [SAMP_W-1:0] y0_re,
    input  logic signed [SAMP_W-1:0] y0_im,
    input  logic signed [SAMP_W-1:0] y1_re,
    input  logic signed [SAMP_W-1:0] y1_im,
    output logic                     out_valid,
    output logic [BITS_W-1:0]        out_bits
);
    samp_t y0_s, y1_s;
    assign y0_s.re = y0_re;
    assign y0_s.im = y0_im;
    assign y1_s.re = y1_re;
    assign y1_s.im = y1_im;

    logic  pair_valid, pair_dual, buf_phase;
    qam_e  pair_mod;
    samp_t a0, b0, a1, b1;

    sfbc_pair_buffer u_buf (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .ant_code(ant_code), .mod_code(mod_code),
        .y0(y0_s), .y1(y1_s),
        .pair_valid(pair_valid), .pair_dual(pair_dual), .pair_mod(pair_mod),
        .a0(a0), .b0(b0), .a1(a1), .b1(b1), .phase(buf_phase)
    );

    logic  comb_valid, comb_dual;
    qam_e  comb_mod;
    comb_t comb_x0, comb_x1;

    sfbc_combiner #(.RECIP_Q(RECIP_Q), .RECIP_SH(RECIP_SH)) u_comb (
        .clk(clk), .rst(rst),
        .pair_valid(pair_valid), .pair_dual(pair_dual), .pair_mod(pair_mod),
        .a0(a0), .b0(b0), .a1(a1), .b1(b1),
        .comb_valid(comb_valid), .comb_mod(comb_mod), .comb_dual(comb_dual),
        .x0(comb_x0), .x1(comb_x1)
    );

    comb_t             lane_x    [NUM_LANES];
    logic [BITS_W-1:0] lane_bits [NUM_LANES];
    assign lane_x[0] = comb_x0;
    assign lane_x[1] = comb_x1;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        sfbc_slicer #(.LVL_UNIT(LVL_UNIT)) u_slc (
            .x(lane_x[g]), .mod(comb_mod), .bits(lane_bits[g])
        );
    end

    logic              slc_valid, slc_dual;
    qam_e              slc_mod;
    logic [BITS_W-1:0] slc_a, slc_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            slc_valid <= 1'b0;
            slc_dual  <= 1'b0;
            slc_mod   <= QAM4;
            slc_a     <= '0;
            slc_b     <= '0;
        end else begin
            slc_valid <= comb_valid;
            slc_dual  <= comb_dual;
            slc_mod   <= comb_mod;
            slc_a     <= lane_bits[0];
            slc_b     <= lane_bits[1];
        end
    end

    logic dly_pend;
    qam_e dly_mod;

    sfbc_delayer u_dly (
        .clk(clk), .rst(rst),
        .slc_valid(slc_valid), .slc_dual(slc_dual), .slc_mod(slc_mod),
        .bits_a(slc_a), .bits_b(slc_b),
        .out_valid(out_valid), .out_bits(out_bits),
        .out_mod(dly_mod), .pend_valid(dly_pend)
    );
endmodule

// File: rtl/sfbc_rx_detect_checker.sv
module sfbc_rx_detect_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [1:0] ant_code,
    input logic       out_valid,
    input logic [5:0] out_bits,
    input logic       buf_phase,
    input logic       pair_valid,
    input logic       slc_valid,
    input logic       dly_pend,
    input logic [1:0] dly_mod
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    assert_single_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ant_code == 2'b01) |-> ##4 out_valid);

    assert_pair_order_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ant_code == 2'b10 && buf_phase) |-> ##4 out_valid ##1 out_valid);

    assert_qpsk_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && dly_mod == 2'b00) |-> (out_bits[5:2] == 4'b0000));

    assert_bad_code_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (ant_code == 2'b00 || ant_code == 2'b11)) |=> !pair_valid);

    assert_no_symbol_loss_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({slc_valid, dly_pend}));
endmodule

bind sfbc_rx_detect sfbc_rx_detect_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ant_code(ant_code),
    .out_valid(out_valid), .out_bits(out_bits), .buf_phase(buf_phase),
    .pair_valid(pair_valid), .slc_valid(slc_valid), .dly_pend(dly_pend),
    .dly_mod(dly_mod)
);

// File: tb/sfbc_rx_detect_tb.sv
module sfbc_rx_detect_tb;
    localparam int CLK_PERIOD = 10;
    localparam int U   = 4096;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [1:0] ant_code = 2'b00;
    logic [1:0] mod_code = 2'b00;
    logic signed [15:0] y0_re = '0, y0_im = '0, y1_re = '0, y1_im = '0;
    logic out_valid;
    logic [5:0] out_bits;

    sfbc_rx_detect u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ant_code(ant_code),
        .mod_code(mod_code), .y0_re(y0_re), .y0_im(y0_im), .y1_re(y1_re),
        .y1_im(y1_im), .out_valid(out_valid), .out_bits(out_bits)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail = 0;
    int out_seen = 0;
    int    exp_bits_q[$];
    int    exp_cyc_q[$];
    string exp_tag_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (exp_cyc_q.size() > 0 && exp_cyc_q[0] < cyc) begin
                check(1'b0, {exp_tag_q[0], " missing output"}, cyc, exp_cyc_q[0]);
                void'(exp_bits_q.pop_front());
                void'(exp_cyc_q.pop_front());
                void'(exp_tag_q.pop_front());
            end
            if (out_valid) begin
                out_seen++;
                if (exp_bits_q.size() == 0) begin
                    check(1'b0, "R7 unexpected output", int'(out_bits), -1);
                end else begin
                    int eb;
                    int ec;
                    string t;
                    eb = exp_bits_q.pop_front();
                    ec = exp_cyc_q.pop_front();
                    t  = exp_tag_q.pop_front();
                    check(int'(out_bits) == eb, {t, " bits"}, int'(out_bits), eb);
                    check(cyc == ec, {t, " cycle"}, cyc, ec);
                end
            end
        end
    end

    function automatic int eff_mod(input int m);
        return (m == 3) ? 0 : m;
    endfunction

    function automatic int nbits(input int m);
        return 2 * (eff_mod(m) + 1);
    endfunction

    function automatic int axis_level(input int m, input bit s, input bit hi, input bit lo);
        int a;
        case (m)
            1:       a = hi ? 3*U : U;
            2:       a = hi ? (lo ? 7*U : 5*U) : (lo ? U : 3*U);
            default: a = U;
        endcase
        return s ? -a : a;
    endfunction

    function automatic void sym_of(input int m, input logic [5:0] b, output int i, output int q);
        case (eff_mod(m))
            1: begin
                i = axis_level(1, b[3], b[1], 1'b0);
                q = axis_level(1, b[2], b[0], 1'b0);
            end
            2: begin
                i = axis_level(2, b[5], b[3], b[1]);
                q = axis_level(2, b[4], b[2], b[0]);
            end
            default: begin
                i = axis_level(0, b[1], 1'b0, 1'b0);
                q = axis_level(0, b[0], 1'b0, 1'b0);
            end
        endcase
    endfunction

    function automatic bit mag_ge(input int v, input int t);
        return (v >= t) || (v <= -t);
    endfunction

    function automatic logic [5:0] slice_ref(input int m, input int i, input int q);
        bit si, sq;
        si = (i < 0);
        sq = (q < 0);
        case (eff_mod(m))
            1: return {2'b00, si, sq, mag_ge(i, 2*U), mag_ge(q, 2*U)};
            2: return {si, sq, mag_ge(i, 4*U), mag_ge(q, 4*U),
                       (!mag_ge(i, 2*U) || mag_ge(i, 6*U)),
                       (!mag_ge(q, 2*U) || mag_ge(q, 6*U))};
            default: return {4'b0000, si, sq};
        endcase
    endfunction

    function automatic int sc(input int v);
        return (v * 7071) / 10000;
    endfunction

    function automatic int noise(input bit on);
        return on ? (int'($urandom_range(0, 800)) - 400) : 0;
    endfunction

    task automatic drive(input logic [1:0] ant, input logic [1:0] m,
                         input int a, input int b, input int c, input int d);
        @(negedge clk);
        in_valid = 1'b1;
        ant_code = ant;
        mod_code = m;
        y0_re = 16'(a);
        y0_im = 16'(b);
        y1_re = 16'(c);
        y1_im = 16'(d);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            ant_code = 2'b00;
        end
    endtask

    task automatic expect_at(input logic [5:0] b, input int c, input string t);
        exp_bits_q.push_back(int'(b));
        exp_cyc_q.push_back(c);
        exp_tag_q.push_back(t);
    endtask

    task automatic send_one(input logic [1:0] m, input int i, input int q,
                            input logic [5:0] eb, input string t);
        drive(2'b01, m, i, q, int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)));
        expect_at(eb, cyc + LAT, t);
    endtask

    task automatic send_pair(input logic [1:0] m_first, input logic [1:0] m,
                             input int x0i, input int x0q, input int x1i, input int x1q,
                             input logic [5:0] eb0, input logic [5:0] eb1,
                             input bit nz, input string t);
        drive(2'b10, m_first, sc(x0i) + noise(nz), sc(x0q) + noise(nz),
              -sc(x1i) + noise(nz), sc(x1q) + noise(nz));
        drive(2'b10, m, sc(x1i) + noise(nz), sc(x1q) + noise(nz),
              sc(x0i) + noise(nz), -sc(x0q) + noise(nz));
        expect_at(eb0, cyc + LAT, {t, " x0"});
        expect_at(eb1, cyc + LAT + 1, {t, " x1"});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int seen0;
        bit last_pair;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(out_bits == 6'd0, "R1 out_bits in reset", int'(out_bits), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after release", int'(out_valid), 0);

        // R4 zero and negative components, code 11 behaves as QPSK
        send_one(2'b00, 0, 0, 6'b000000, "R4 zero");
        send_one(2'b00, -1, 0, 6'b000010, "R4 neg I");
        send_one(2'b11, 5, -7, 6'b000001, "R4 code11");
        // R5 thresholds at 2U, R2 unscaled single-port path
        send_one(2'b01, 2*U, 2*U - 1, slice_ref(1, 2*U, 2*U - 1), "R5 edge pos");
        send_one(2'b01, -2*U, -(2*U - 1), slice_ref(1, -2*U, -(2*U - 1)), "R5 edge neg");
        // R6 thresholds at 4U and 6U
        send_one(2'b10, 4*U, 6*U, 6'b001101, "R6 edge hi");
        send_one(2'b10, 4*U - 1, 6*U - 1, slice_ref(2, 4*U - 1, 6*U - 1), "R6 edge lo");
        send_one(2'b10, -2*U + 1, -2*U, slice_ref(2, -2*U + 1, -2*U), "R6 edge inner");
        idle(6);

        // R3 exact pair without noise, R9 order
        send_pair(2'b10, 2'b10, 7*U, -U, -5*U, 3*U,
                  slice_ref(2, 7*U, -U), slice_ref(2, -5*U, 3*U), 1'b0, "R3 exact");
        // R9 back-to-back pairs
        send_pair(2'b00, 2'b00, U, -U, -U, U, 6'b000001, 6'b000010, 1'b1, "R9 burst a");
        send_pair(2'b01, 2'b01, -3*U, U, U, -3*U,
                  slice_ref(1, -3*U, U), slice_ref(1, U, -3*U), 1'b1, "R9 burst b");
        idle(2);
        // R8 first-sample modulation code ignored
        send_pair(2'b01, 2'b00, -U, U, U, -U, 6'b000010, 6'b000001, 1'b0, "R8 mod from second");
        idle(2);

        // R7 half pair discarded by a bad code, then a clean pair
        drive(2'b10, 2'b00, 20000, 20000, 20000, 20000);
        drive(2'b00, 2'b00, 1, 1, 1, 1);
        send_pair(2'b00, 2'b00, -U, -U, U, U, 6'b000011, 6'b000000, 1'b0, "R7 after drop");
        seen0 = out_seen + 2;
        drive(2'b11, 2'b00, 100, 100, 100, 100);
        drive(2'b00, 2'b10, -100, -100, -100, -100);
        idle(8);
        check(out_seen == seen0, "R7 bad codes silent", out_seen, seen0);

        // Random loopback through the transmit-code model (R2, R3, R4, R5, R6, R9)
        last_pair = 1'b0;
        for (int k = 0; k < 400; k++) begin
            int m;
            int i0, q0, i1, q1;
            logic [5:0] b0, b1, mask;
            m = int'($urandom_range(0, 3));
            mask = 6'((1 << nbits(m)) - 1);
            b0 = 6'($urandom) & mask;
            b1 = 6'($urandom) & mask;
            sym_of(m, b0, i0, q0);
            sym_of(m, b1, i1, q1);
            if ($urandom_range(0, 1) == 0) begin
                if (last_pair) idle(1);
                send_one(2'(m), i0 + noise(1'b1), q0 + noise(1'b1), b0, "R2 random single");
                last_pair = 1'b0;
            end else begin
                send_pair(2'(m), 2'(m), i0, q0, i1, q1, b0, b1, 1'b1, "R3 random pair");
                last_pair = 1'b1;
            end
            if ($urandom_range(0, 3) == 0) begin
                idle(1);
                last_pair = 1'b0;
            end
        end
        idle(10);
        check(exp_bits_q.size() == 0, "R9 all symbols delivered", exp_bits_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule